// File: doc/BRIEF.md
# Packed Integer Compare-to-Mask Unit

This unit compares up to sixteen 32-bit integer lanes taken from two 512-bit vector operands and turns each comparison into a single bit of a 16-bit result mask. A three-bit predicate code selects the relation for each lane. Each lane can be tested for equality, less-than or less-or-equal, for the inverse of any of these, or forced to constant false or constant true. A mode bit selects whether the lanes are treated as two's-complement or unsigned values.

The vector length selects how many lanes take part: 4, 8 or 16. Mask bits above the active lanes are always cleared. A broadcast option compares every lane of the first operand against the lowest 32 bits of the second operand. An optional writemask clears individual result bits, and cleared bits are zeroed, never merged with an earlier result. The result is captured in a register one clock after a valid strobe. The register holds its value until the next strobe.

Top module: `pcmp_mask_unit`

## Requirements
- R1: `pred_imm[2:0]` selects the lane relation between lane A and lane B: 0 A==B, 1 A<B, 2 A<=B, 3 constant 0, 4 A!=B, 5 not A<B, 6 not A<=B, 7 constant 1.
- R2: `pred_imm[7:3]` has no effect on the result.
- R3: `vlen_sel` 0, 1 and 2 make 4, 8 and 16 lanes active (3 behaves as 2). Lane j uses source bits [32j+31:32j].
- R4: With `is_signed`=1, lanes compare as two's-complement values, so 0x80000000 < 0x7FFFFFFF.
- R5: With `is_signed`=0, lanes compare as unsigned values, so 0x7FFFFFFF < 0x80000000 and 0xFFFFFFFF is the largest value.
- R6: With `wmask_en`=1, any lane whose `wmask` bit is 0 gives a result bit of 0.
- R7: With `wmask_en`=0, every active lane gives its comparison result, whatever value `wmask` holds.
- R8: With `bcast_en`=1, every lane compares against `src_b[31:0]` instead of its own slice of `src_b`.
- R9: Result bits at or above the active lane count are 0.
- R10: `wmask` bits at or above the active lane count have no effect.
- R11: A result appears on `out_mask` with `out_valid`=1 in the cycle after `in_valid`=1. `out_valid` is 0 in any other cycle, and `out_mask` holds its last value while `in_valid` is 0.
- R12: A synchronous active-high `rst` clears `out_mask` and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| src_a | input | 512 | First source vector, 16 lanes of 32 bits |
| src_b | input | 512 | Second source vector, or a scalar in bits [31:0] when broadcast is on |
| vlen_sel | input | 2 | Active length: 0 = 4 lanes, 1 = 8 lanes, 2 or 3 = 16 lanes |
| is_signed | input | 1 | 1 = two's-complement compare, 0 = unsigned compare |
| pred_imm | input | 8 | Predicate code in bits [2:0]; bits [7:3] are ignored |
| bcast_en | input | 1 | Compare every lane against src_b[31:0] |
| wmask | input | 16 | Per-lane zeroing writemask |
| wmask_en | input | 1 | The writemask is applied |
| out_valid | output | 1 | out_mask holds a new result |
| out_mask | output | 16 | Registered result mask |

## Verification
The assertions check on every result cycle that the valid flag follows the strobe by one cycle. They also check that bits above the registered length are zero and that lanes cleared by an applied writemask are zero. The constant predicates must produce an all-zero mask or a mask with exactly one bit set per active lane. How each lane's relation is decided cannot be shown by a property. This covers signed against unsigned ordering at 0x80000000 and 0x7FFFFFFF, the selection of broadcast operands, and the independence from the reserved predicate bits. Only the bench scenarios show these, by comparing the outputs against a separate behavioural model and against hand-worked lane values.

// File: rtl/pcmp_mask_unit.sv
module pcmp_mask_unit #(
  parameter int LANES = 16,
  parameter int LW    = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [LANES*LW-1:0] src_a,
  input  logic [LANES*LW-1:0] src_b,
  input  logic [1:0]          vlen_sel,
  input  logic                is_signed,
  input  logic [7:0]          pred_imm,
  input  logic                bcast_en,
  input  logic [LANES-1:0]    wmask,
  input  logic                wmask_en,
  output logic                out_valid,
  output logic [LANES-1:0]    out_mask
);

  localparam int CW = $clog2(LANES + 1);

  logic [CW-1:0]    n_act;
  logic [LANES-1:0] act;
  logic [LANES-1:0] res;

  assign n_act = (vlen_sel >= 2'd2) ? CW'(LANES) : CW'(LANES >> (2 - vlen_sel));

  always_comb
    for (int j = 0; j < LANES; j++)
      act[j] = (j < int'(n_act));

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LW-1:0] a, b;
    logic          eq, lt, base;
    assign a  = src_a[j*LW +: LW];
    assign b  = bcast_en ? src_b[LW-1:0] : src_b[j*LW +: LW];
    assign eq = (a == b);
    assign lt = $signed({is_signed & a[LW-1], a}) < $signed({is_signed & b[LW-1], b});
    always_comb
      case (pred_imm[1:0])
        2'd0:    base = eq;
        2'd1:    base = lt;
        2'd2:    base = lt | eq;
        default: base = 1'b0;
      endcase
    assign res[j] = (base ^ pred_imm[2]) & act[j] & (~wmask_en | wmask[j]);
  end

  always_ff @(posedge clk)
    if (rst) begin
      out_valid <= 1'b0;
      out_mask  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_mask <= res;
    end

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r11_valid_only_after_strobe: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r9_upper_bits_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(vlen_sel) == 2'd0) |-> (out_mask[LANES-1:LANES/4] == '0));

  a_r6_wmask_zeroes: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(wmask_en)) |-> ((out_mask & ~$past(wmask)) == '0));

  a_r1_const_false: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(pred_imm[2:0]) == 3'd3) |-> (out_mask == '0));

  a_r1_const_true: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(pred_imm[2:0]) == 3'd7 && !$past(wmask_en)) |->
    ($countones(out_mask) == (($past(vlen_sel) >= 2'd2) ? LANES : (LANES >> (2 - $past(vlen_sel))))));

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid) |-> $stable(out_mask));

endmodule

// File: tb/pcmp_mask_unit_test.sv
module pcmp_mask_unit_test;
  logic         clk = 0, rst = 1, in_valid = 0;
  logic [511:0] src_a = '0, src_b = '0;
  logic [1:0]   vlen_sel = 2'd2;
  logic         is_signed = 0, bcast_en = 0, wmask_en = 0;
  logic [7:0]   pred_imm = '0;
  logic [15:0]  wmask = '0;
  logic         out_valid;
  logic [15:0]  out_mask;
  int total = 0, bad = 0;
  logic [15:0]  last_exp;

  pcmp_mask_unit uut (.clk, .rst, .in_valid, .src_a, .src_b, .vlen_sel, .is_signed,
    .pred_imm, .bcast_en, .wmask, .wmask_en, .out_valid, .out_mask);

  always #5 clk = ~clk;

  function automatic logic [15:0] model(input logic [511:0] a, b, input logic [1:0] vl,
      input logic sg, input logic [7:0] p, input logic bc, input logic [15:0] wm, input logic we);
    int n = (vl == 0) ? 4 : (vl == 1) ? 8 : 16;
    logic [15:0] m = '0;
    for (int j = 0; j < 16; j++) begin
      logic [31:0] x, y;
      logic l, e, r;
      x = a[j*32 +: 32];
      y = bc ? b[31:0] : b[j*32 +: 32];
      e = (x == y);
      l = sg ? ($signed(x) < $signed(y)) : (x < y);
      case (p[2:0])
        3'd0: r = e;       3'd1: r = l;       3'd2: r = l | e;    3'd3: r = 0;
        3'd4: r = !e;      3'd5: r = !l;      3'd6: r = !(l | e); default: r = 1;
      endcase
      if (j < n && (!we || wm[j])) m[j] = r;
    end
    return m;
  endfunction

  task automatic check(input string req, input logic [15:0] got, exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run(input string req);
    logic [15:0] e;
    e = model(src_a, src_b, vlen_sel, is_signed, pred_imm, bcast_en, wmask, wmask_en);
    @(negedge clk) in_valid = 1;
    @(negedge clk) in_valid = 0;
    check({req, " valid"}, {15'd0, out_valid}, 16'd1);
    check(req, out_mask, e);
    last_exp = e;
  endtask

  task automatic load_boundary();
    logic [31:0] v [5] = '{32'h80000000, 32'h7FFFFFFF, 32'h0, 32'hFFFFFFFF, 32'h1};
    for (int k = 0; k < 16; k++) begin
      src_a[k*32 +: 32] = v[k % 5];
      src_b[k*32 +: 32] = v[(k / 3) % 5];
    end
  endtask

  task automatic t_reset();
    check("R12 valid", {15'd0, out_valid}, 16'd0);
    check("R12 mask", out_mask, 16'd0);
  endtask

  task automatic t_preds();
    load_boundary();
    vlen_sel = 2'd2; wmask_en = 0; bcast_en = 0;
    for (int s = 0; s < 2; s++) begin
      is_signed = s[0];
      for (int p = 0; p < 8; p++) begin
        pred_imm = p[7:0];
        run(s ? "R1 R4 signed pred" : "R1 R5 unsigned pred");
      end
    end
  endtask

  task automatic t_boundary_hand();
    src_a = '0; src_b = '0;
    src_a[31:0] = 32'h80000000; src_b[31:0] = 32'h7FFFFFFF;
    vlen_sel = 2'd0; pred_imm = 8'd1; wmask_en = 0; bcast_en = 0;
    is_signed = 1; run("R4 hand");
    check("R4 lane0 lt", out_mask, 16'h0001);
    is_signed = 0; run("R5 hand");
    check("R5 lane0 not lt", out_mask, 16'h0000);
  endtask

  task automatic t_lengths();
    load_boundary();
    pred_imm = 8'd7; wmask_en = 0; wmask = 16'h0000; bcast_en = 0;
    vlen_sel = 2'd0; run("R3 R9 len4");  check("R7 R9 len4 true", out_mask, 16'h000F);
    vlen_sel = 2'd1; run("R3 R9 len8");  check("R7 len8 true", out_mask, 16'h00FF);
    vlen_sel = 2'd2; run("R3 len16");    check("R7 len16 true", out_mask, 16'hFFFF);
    vlen_sel = 2'd3; run("R3 len code3"); check("R3 code3 true", out_mask, 16'hFFFF);
    pred_imm = 8'd4; vlen_sel = 2'd1; is_signed = 1; run("R3 R9 len8 neq");
  endtask

  task automatic t_wmask();
    load_boundary();
    pred_imm = 8'd7; vlen_sel = 2'd2; wmask_en = 1; wmask = 16'hA5C3;
    run("R6 wmask");
    check("R6 wmask true", out_mask, 16'hA5C3);
    vlen_sel = 2'd0; wmask = 16'hFFF5; run("R10 high wmask bits");
    check("R10 high wmask ignored", out_mask, 16'h0005);
    pred_imm = 8'd2; is_signed = 1; vlen_sel = 2'd1; wmask = 16'h3C0F; run("R6 wmask le");
  endtask

  task automatic t_reserved();
    load_boundary();
    vlen_sel = 2'd2; wmask_en = 0; bcast_en = 0; is_signed = 1;
    pred_imm = 8'h01; run("R2 base");
    pred_imm = 8'hF9; run("R2 reserved set");
    check("R2 reserved same", out_mask, model(src_a, src_b, 2'd2, 1'b1, 8'h01, 1'b0, 16'h0, 1'b0));
  endtask

  task automatic t_bcast();
    for (int k = 0; k < 16; k++) begin
      src_a[k*32 +: 32] = 32'(k) - 32'd4;
      src_b[k*32 +: 32] = 32'hDEAD0000 + 32'(k);
    end
    src_b[31:0] = 32'd3;
    bcast_en = 1; vlen_sel = 2'd2; wmask_en = 0; pred_imm = 8'd1;
    is_signed = 1; run("R8 bcast signed");
    check("R8 bcast lt 3", out_mask, 16'h007F);
    is_signed = 0; run("R8 bcast unsigned");
    check("R8 bcast unsigned lt 3", out_mask, 16'h0070);
    bcast_en = 0;
  endtask

  task automatic t_hold();
    @(negedge clk);
    check("R11 no valid", {15'd0, out_valid}, 16'd0);
    check("R11 mask held", out_mask, last_exp);
  endtask

  task automatic t_random();
    for (int n = 0; n < 40; n++) begin
      for (int k = 0; k < 16; k++) begin
        src_a[k*32 +: 32] = $urandom;
        src_b[k*32 +: 32] = ($urandom % 3 == 0) ? src_a[k*32 +: 32] : $urandom;
      end
      vlen_sel = 2'($urandom); is_signed = 1'($urandom); pred_imm = 8'($urandom);
      bcast_en = 1'($urandom); wmask = 16'($urandom); wmask_en = 1'($urandom);
      run("R1 R3 R6 R8 random");
    end
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    t_preds();
    t_boundary_hand();
    t_lengths();
    t_wmask();
    t_reserved();
    t_bcast();
    t_hold();
    t_random();
    t_hold();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule